// File: doc/BRIEF.md
# Three-Wire Serial Memory Target

This block acts as the memory side of a three-wire serial link made of a select line, a shift clock and a data input, plus a data output. The select line, the shift clock and the data input are brought into the system clock domain through a short synchroniser. Each rising shift-clock edge is turned into a one-cycle event. The block collects a start bit, a two-bit opcode and an address, then serves the command from an internal 4096-bit register array.

The array can be viewed as 512 bytes (`wide_sel` = 0) or as 256 sixteen-bit words (`wide_sel` = 1). Programming commands only take effect while an internal enable latch is set. Each accepted programming command starts a self-timed busy period of `PROG_CYCLES` system clocks. If the host drops `cs` and raises it again during that period, the data output reports busy/ready.

The controller is one state machine:
- `ST_IDLE` moves to `ST_STATUS` when `cs` is seen high during a busy period, and to `ST_START` otherwise.
- `ST_START` moves to `ST_OPC` on a 1 bit.
- `ST_OPC` moves to `ST_ADDR` after two bits.
- `ST_ADDR` moves to one of three states after its last bit:
  - `ST_READ` for a read;
  - `ST_DATA` for write or write-all;
  - `ST_HOLD` for every other command.
- `ST_DATA` moves to `ST_HOLD` after its last bit.
- `ST_READ`, `ST_HOLD` and `ST_STATUS` stay where they are until `cs` goes low.
- `cs` low forces `ST_IDLE` from every state.

Top module: `serial_mem_target`

## Requirements
- R1: After reset `sdo_oe` is 0, programming is disabled, and every array byte reads as 8'hFF.
- R2: While waiting for an instruction, 0 bits are skipped. A 1 bit starts the frame. It is followed by a 2-bit opcode (MSB first: 10 read, 01 write, 11 erase, 00 extended) and then an address, MSB first, of 9 bits when `wide_sel`=0 and 8 bits when `wide_sel`=1.
- R3: On a read, the block drives a 0 dummy bit in response to the sclk rising edge that carries the last address bit. The addressed word then follows MSB first, one bit per later sclk rising edge.
- R4: While `cs` stays high, a read continues with the next address and sends no further dummy bit. The address wraps from the top (511 bytes or 255 words) to 0.
- R5: In 16-bit mode, word n is byte 2n in bits 15:8 and byte 2n+1 in bits 7:0.
- R6: An enabled write stores its 8- or 16-bit data, MSB first after the address, with no prior erase needed.
- R7: An enabled erase sets the addressed word to all ones. An enabled erase-all sets the whole array to all ones.
- R8: An enabled write-all stores its data pattern in every word.
- R9: While programming is disabled, erase, write, erase-all and write-all leave the array unchanged. Read works whether programming is enabled or disabled.
- R10: Each accepted programming command makes the block busy for `PROG_CYCLES` clocks. If `cs` is raised again during that time, `sdo_oe`=1 and `sdo` shows 0 until the busy time ends, then 1. If `cs` is raised after the busy time has ended, `sdo_oe` stays 0.
- R11: `sdo_oe` falls within a few clocks of `cs` going low. Bits shifted in while status is being shown are ignored.
- R12: For the extended opcode, the two top address bits select the command: 11 enable programming, 00 disable programming, 10 erase-all, 01 write-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Select line, asynchronous |
| sclk | input | 1 | Shift clock, asynchronous |
| sdi | input | 1 | Serial data input, asynchronous |
| wide_sel | input | 1 | 1 = 16-bit words, 0 = bytes; held static |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |

## Verification
The hardest state to reach is the busy report. The host has to finish a programming command, drop `cs`, and raise it again before `PROG_CYCLES` expire. The report then has to be observed flipping from 0 to 1 without any further shift clocks. The bench uses a deliberately short busy period. It raises `cs` a few clocks after the last data bit and clocks in a complete second write while the status is shown. It then checks that the second write was dropped. A second run waits out the busy period before raising `cs`, to show that no status is driven.

// File: rtl/smt_pkg.sv
package smt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD,
        ST_STATUS
    } smt_state_e;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_WORD,
        WOP_ERASE,
        WOP_FILL,
        WOP_CLEAR
    } wr_op_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK  = 2'b00;
    localparam logic [1:0] SUB_FILL  = 2'b01;
    localparam logic [1:0] SUB_CLEAR = 2'b10;
    localparam logic [1:0] SUB_OPEN  = 2'b11;

endpackage

// File: rtl/smt_sync.sv
module smt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_a,
    input  logic sclk_a,
    input  logic sdi_a,
    output logic cs_s,
    output logic sdi_s,
    output logic sclk_rise
);

    logic [STAGES-1:0] cs_p, sk_p, di_p;
    logic              sk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p    <= '0;
            sk_p    <= '0;
            di_p    <= '0;
            sk_last <= 1'b0;
        end else begin
            cs_p    <= {cs_p[STAGES-2:0], cs_a};
            sk_p    <= {sk_p[STAGES-2:0], sclk_a};
            di_p    <= {di_p[STAGES-2:0], sdi_a};
            sk_last <= sk_p[STAGES-1];
        end
    end

    assign cs_s      = cs_p[STAGES-1];
    assign sdi_s     = di_p[STAGES-1];
    assign sclk_rise = sk_p[STAGES-1] & ~sk_last;

    // a detected edge can never repeat on the next cycle
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !sclk_rise);

endmodule

// File: rtl/smt_prog_timer.sv
module smt_prog_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CNT_W'(PROG_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/smt_array.sv
module smt_array
    import smt_pkg::*;
#(
    parameter int ADDR8_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wide,
    input  wr_op_e             wr_op,
    input  logic [ADDR8_W-1:0] wr_addr,
    input  logic [15:0]        wr_data,
    input  logic [ADDR8_W-1:0] rd_addr,
    output logic [15:0]        rd_word
);

    localparam int BYTE_N = 1 << ADDR8_W;

    logic [7:0] mem [BYTE_N];

    logic [ADDR8_W-1:0] wr_hi, wr_lo, rd_hi, rd_lo;
    assign wr_hi = {wr_addr[ADDR8_W-2:0], 1'b0};
    assign wr_lo = {wr_addr[ADDR8_W-2:0], 1'b1};
    assign rd_hi = {rd_addr[ADDR8_W-2:0], 1'b0};
    assign rd_lo = {rd_addr[ADDR8_W-2:0], 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BYTE_N; i++) mem[i] <= 8'hFF;
        end else begin
            unique case (wr_op)
                WOP_WORD: begin
                    if (wide) begin
                        mem[wr_hi] <= wr_data[15:8];
                        mem[wr_lo] <= wr_data[7:0];
                    end else begin
                        mem[wr_addr] <= wr_data[7:0];
                    end
                end
                WOP_ERASE: begin
                    if (wide) begin
                        mem[wr_hi] <= 8'hFF;
                        mem[wr_lo] <= 8'hFF;
                    end else begin
                        mem[wr_addr] <= 8'hFF;
                    end
                end
                WOP_FILL: begin
                    for (int i = 0; i < BYTE_N; i++)
                        mem[i] <= (wide && !i[0]) ? wr_data[15:8] : wr_data[7:0];
                end
                WOP_CLEAR: begin
                    for (int i = 0; i < BYTE_N; i++) mem[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    assign rd_word = wide ? {mem[rd_hi], mem[rd_lo]} : {8'h00, mem[rd_addr]};

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_op == WOP_CLEAR) |=> (mem[0] == 8'hFF) && (mem[BYTE_N-1] == 8'hFF));

    assert_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_op == WOP_FILL && !wide) |=> (mem[BYTE_N-1] == $past(wr_data[7:0])));

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import smt_pkg::*;
#(
    parameter int ADDR8_W     = 9,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    input  logic wide_sel,
    output logic sdo,
    output logic sdo_oe
);

    localparam int ADDR16_W = ADDR8_W - 1;

    smt_state_e state, state_n;

    logic               cs_s, sdi_s, sclk_rise, busy;
    logic [4:0]         bitcnt;
    logic [1:0]         opc;
    logic [ADDR8_W-2:0] addr_sh;
    logic [ADDR8_W-1:0] addr_nx;
    logic [14:0]        data_sh;
    logic [15:0]        data_nx;
    logic               we_en;
    logic [ADDR8_W-1:0] rd_ptr, rd_ptr_inc;
    logic [3:0]         rd_idx;
    wr_op_e             wr_op;
    logic [ADDR8_W-1:0] wr_addr;
    logic [15:0]        wr_data;
    logic [15:0]        rd_word, word_al;
    logic               addr_last, data_last, rd_last, read_bit;
    logic [1:0]         sub;
    logic               sdo_q, oe_q;

    smt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_a(cs), .sclk_a(sclk), .sdi_a(sdi),
        .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise)
    );

    smt_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(wr_op != WOP_NONE), .busy(busy)
    );

    smt_array #(.ADDR8_W(ADDR8_W)) u_array (
        .clk(clk), .rst(rst), .wide(wide_sel), .wr_op(wr_op),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_ptr), .rd_word(rd_word)
    );

    assign addr_nx   = {addr_sh, sdi_s};
    assign data_nx   = {data_sh, sdi_s};
    assign addr_last = (bitcnt == (wide_sel ? 5'(ADDR16_W - 1) : 5'(ADDR8_W - 1)));
    assign data_last = (bitcnt == (wide_sel ? 5'd15 : 5'd7));
    assign rd_last   = (rd_idx == (wide_sel ? 4'd15 : 4'd7));
    assign sub       = wide_sel ? addr_nx[ADDR16_W-1 -: 2] : addr_nx[ADDR8_W-1 -: 2];
    assign word_al   = wide_sel ? rd_word : {rd_word[7:0], 8'h00};
    assign read_bit  = word_al[4'd15 - rd_idx];
    assign rd_ptr_inc = wide_sel ? {1'b0, rd_ptr[ADDR16_W-1:0] + 1'b1} : rd_ptr + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (cs_s) state_n = busy ? ST_STATUS : ST_START;
            ST_START:  if (sclk_rise && sdi_s) state_n = ST_OPC;
            ST_OPC:    if (sclk_rise && bitcnt == 5'd1) state_n = ST_ADDR;
            ST_ADDR: begin
                if (sclk_rise && addr_last) begin
                    unique case (opc)
                        OPC_READ:  state_n = ST_READ;
                        OPC_WRITE: state_n = ST_DATA;
                        OPC_ERASE: state_n = ST_HOLD;
                        default:   state_n = (sub == SUB_FILL) ? ST_DATA : ST_HOLD;
                    endcase
                end
            end
            ST_DATA:   if (sclk_rise && data_last) state_n = ST_HOLD;
            ST_READ, ST_HOLD, ST_STATUS: state_n = state;
            default:   state_n = ST_IDLE;
        endcase
        if (!cs_s) state_n = ST_IDLE;
    end

    // shift registers, enable latch and programming requests
    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt  <= '0;
            opc     <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            we_en   <= 1'b0;
            rd_ptr  <= '0;
            rd_idx  <= '0;
            wr_op   <= WOP_NONE;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_op <= WOP_NONE;
            if (sclk_rise) begin
                unique case (state)
                    ST_START: begin
                        if (sdi_s) begin
                            bitcnt  <= '0;
                            opc     <= '0;
                            addr_sh <= '0;
                            data_sh <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc    <= {opc[0], sdi_s};
                        bitcnt <= (bitcnt == 5'd1) ? 5'd0 : bitcnt + 5'd1;
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_nx[ADDR8_W-2:0];
                        bitcnt  <= bitcnt + 5'd1;
                        if (addr_last) begin
                            bitcnt <= '0;
                            unique case (opc)
                                OPC_READ: begin
                                    rd_ptr <= wide_sel ? {1'b0, addr_nx[ADDR16_W-1:0]} : addr_nx;
                                    rd_idx <= '0;
                                end
                                OPC_WRITE: wr_addr <= addr_nx;
                                OPC_ERASE: begin
                                    if (we_en) begin
                                        wr_op   <= WOP_ERASE;
                                        wr_addr <= addr_nx;
                                    end
                                end
                                default: begin
                                    unique case (sub)
                                        SUB_OPEN:  we_en <= 1'b1;
                                        SUB_LOCK:  we_en <= 1'b0;
                                        SUB_CLEAR: if (we_en) wr_op <= WOP_CLEAR;
                                        default: ;
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        data_sh <= data_nx[14:0];
                        bitcnt  <= bitcnt + 5'd1;
                        if (data_last) begin
                            bitcnt <= '0;
                            if (we_en) begin
                                wr_op   <= (opc == OPC_WRITE) ? WOP_WORD : WOP_FILL;
                                wr_data <= data_nx;
                            end
                        end
                    end
                    ST_READ: begin
                        if (rd_last) begin
                            rd_idx <= '0;
                            rd_ptr <= rd_ptr_inc;
                        end else begin
                            rd_idx <= rd_idx + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (state_n == ST_READ) || (state_n == ST_STATUS);
            if (state_n == ST_STATUS)
                sdo_q <= !busy;
            else if (sclk_rise && state == ST_ADDR && addr_last && opc == OPC_READ)
                sdo_q <= 1'b0;
            else if (sclk_rise && state == ST_READ)
                sdo_q <= read_bit;
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = oe_q;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!we_en && !sdo_oe));

    assert_oe_low_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !sdo_oe);

    assert_prog_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_op != WOP_NONE) |-> we_en);

    assert_read_dummy_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdo_oe) && state == ST_READ) |-> !sdo);

endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;

    localparam int CLK_PERIOD = 10;
    localparam int PROG = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, wide_sel = 1'b0;
    logic sdo, sdo_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_mem_target #(.ADDR8_W(9), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi),
        .wide_sel(wide_sel), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // {wide, addr, data, expected}
    localparam logic [41:0] VEC [6] = '{
        {1'b0, 9'h000, 16'h00A5, 16'h00A5},
        {1'b0, 9'h1FF, 16'h003C, 16'h003C},
        {1'b1, 9'h000, 16'h1234, 16'h1234},
        {1'b1, 9'h0FF, 16'hBEEF, 16'hBEEF},
        {1'b0, 9'h005, 16'h0000, 16'h0000},
        {1'b1, 9'h07F, 16'h8001, 16'h8001}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b, output logic o);
        sdi = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        o = sdo_oe ? sdo : 1'bz;
        sclk = 1'b0;
        repeat (1) @(negedge clk);
    endtask

    task automatic send_header(input logic w, input logic [1:0] op, input logic [8:0] addr,
                               input int zeros, output logic last_o);
        logic o;
        int aw;
        aw = w ? 8 : 9;
        wide_sel = w;
        cs = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < zeros; i++) pulse(1'b0, o);
        pulse(1'b1, o);
        pulse(op[1], o);
        pulse(op[0], o);
        for (int i = aw - 1; i >= 0; i--) pulse(addr[i], o);
        last_o = o;
    endtask

    task automatic send_data(input logic w, input logic [15:0] d);
        logic o;
        int dw;
        dw = w ? 16 : 8;
        for (int i = dw - 1; i >= 0; i--) pulse(d[i], o);
    endtask

    task automatic end_cmd();
        cs = 1'b0;
        sdi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic simple_cmd(input logic w, input logic [8:0] addr);
        logic o;
        send_header(w, 2'b00, addr, 0, o);
        end_cmd();
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic write_word(input logic w, input logic [8:0] addr, input logic [15:0] d);
        logic o;
        send_header(w, 2'b01, addr, 0, o);
        send_data(w, d);
        end_cmd();
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic read_chk(input logic w, input logic [8:0] addr, input int nwords,
                            input logic [47:0] exp, input int zeros, input string req);
        logic o;
        logic [15:0] word;
        int dw;
        dw = w ? 16 : 8;
        send_header(w, 2'b10, addr, zeros, o);
        check(o === 1'b0, "R3 dummy bit", {15'd0, o}, 16'h0000);
        for (int k = 0; k < nwords; k++) begin
            word = '0;
            for (int b = 0; b < dw; b++) begin
                pulse(1'b0, o);
                word = {word[14:0], o};
            end
            check(word === exp[47 - 16 * k -: 16], req, word, exp[47 - 16 * k -: 16]);
        end
        end_cmd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic o;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check(sdo_oe === 1'b0, "R1 oe after reset", {15'd0, sdo_oe}, 16'h0000);
        read_chk(1'b0, 9'h000, 1, {16'h00FF, 32'h0}, 0, "R1 erased after reset");

        // R9: disabled write ignored, read still works
        write_word(1'b0, 9'h003, 16'h0055);
        read_chk(1'b0, 9'h003, 1, {16'h00FF, 32'h0}, 0, "R9 write while disabled");

        // R12: enable via 11 sub-code
        simple_cmd(1'b0, 9'h180);

        // R6 R2: table of write/read-back vectors
        for (int v = 0; v < 6; v++) begin
            write_word(VEC[v][41], VEC[v][40:32], VEC[v][31:16]);
            read_chk(VEC[v][41], VEC[v][40:32], 1, {VEC[v][15:0], 32'h0}, 0, "R6 write then read");
        end

        // R5: word/byte mapping
        read_chk(1'b0, 9'h000, 1, {16'h0012, 32'h0}, 0, "R5 upper byte");
        read_chk(1'b0, 9'h001, 1, {16'h0034, 32'h0}, 0, "R5 lower byte");

        // R4 + R2 leading zeros: sequential with wrap
        read_chk(1'b0, 9'h1FF, 3, {16'h00EF, 16'h0012, 16'h0034}, 2, "R4 byte sequential wrap");
        read_chk(1'b1, 9'h0FF, 2, {16'hBEEF, 16'h1234, 16'h0}, 0, "R4 word sequential wrap");

        // R7: erase one word
        send_header(1'b1, 2'b11, 9'h07F, 0, o);
        end_cmd();
        repeat (PROG + 20) @(negedge clk);
        read_chk(1'b1, 9'h07F, 1, {16'hFFFF, 32'h0}, 0, "R7 erase word");

        // R10 R11: busy status and ignored input
        send_header(1'b0, 2'b01, 9'h010, 0, o);
        send_data(1'b0, 16'h0077);
        cs = 1'b0;
        repeat (4) @(negedge clk);
        check(sdo_oe === 1'b0, "R11 oe low with cs low", {15'd0, sdo_oe}, 16'h0000);
        cs = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo_oe === 1'b1 && sdo === 1'b0, "R10 busy shown", {14'd0, sdo_oe, sdo}, 16'h0002);
        pulse(1'b1, o); pulse(1'b0, o); pulse(1'b1, o);
        for (int i = 8; i >= 0; i--) pulse(i == 0 || i == 4, o);
        send_data(1'b0, 16'h0099);
        repeat (PROG + 10) @(negedge clk);
        check(sdo_oe === 1'b1 && sdo === 1'b1, "R10 ready shown", {14'd0, sdo_oe, sdo}, 16'h0003);
        end_cmd();
        read_chk(1'b0, 9'h010, 1, {16'h0077, 32'h0}, 0, "R10 data after busy");
        read_chk(1'b0, 9'h011, 1, {16'h00FF, 32'h0}, 0, "R11 input during status ignored");

        // R10: no status after busy ends
        send_header(1'b0, 2'b01, 9'h012, 0, o);
        send_data(1'b0, 16'h0066);
        cs = 1'b0;
        repeat (PROG + 20) @(negedge clk);
        cs = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo_oe === 1'b0, "R10 no status after cycle", {15'd0, sdo_oe}, 16'h0000);
        end_cmd();

        // R8 R12: write-all with 01 sub-code in 16-bit mode
        send_header(1'b1, 2'b00, 9'h040, 0, o);
        send_data(1'b1, 16'h5AC3);
        end_cmd();
        repeat (PROG + 20) @(negedge clk);
        read_chk(1'b0, 9'h000, 1, {16'h005A, 32'h0}, 0, "R8 fill even byte");
        read_chk(1'b0, 9'h1FF, 1, {16'h00C3, 32'h0}, 0, "R8 fill odd byte");
        read_chk(1'b1, 9'h040, 1, {16'h5AC3, 32'h0}, 0, "R8 fill word");

        // R7 R12: erase-all with 10 sub-code
        simple_cmd(1'b0, 9'h100);
        read_chk(1'b1, 9'h000, 1, {16'hFFFF, 32'h0}, 0, "R7 erase all");

        // R9 R12: disable with 00 sub-code, then write ignored
        simple_cmd(1'b1, 9'h000);
        write_word(1'b0, 9'h002, 16'h0011);
        read_chk(1'b0, 9'h002, 1, {16'h00FF, 32'h0}, 0, "R9 write after disable");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule